// File: doc/BRIEF.md
# DRAM Channel Select and Address Normalizer

This block sits behind the node address decoder of a memory controller that drives two DRAM channels. It accepts a node-local system address together with the node's controller-select configuration and decides which of the two channels owns the address. It then takes away the right base offset, which is either the range base, the select-base offset or the hoisting offset of the memory hole. Last, it removes the address bits used by node interleaving and by channel interleaving, so that what remains is a dense channel-relative address ready for chip-select matching.

The channel decision is a priority chain. Gang mode comes first, then the high range, then three interleave styles: plain bit 6, a parity hash over bits 20:16, and page interleave. The block is a two-stage pipeline. Configuration is sampled together with each request, so settings may change between requests.

Top module: `dram_chan_norm`

## Requirements
- R1: The high range is selected exactly when hi_rng_en_i is 1, gang_en_i is 0 and addr_i >= sel_base_i * 2^27.
- R2: With gang_en_i = 1, chan_o equals addr_i[3], whatever the other select fields hold.
- R3: When gang mode is off and the high range is selected, chan_o equals hi_chan_i.
- R4: When gang is off, the high range is not selected, ilv_en_i = 1 and ilv_mode_i = 0, chan_o equals addr_i[6].
- R5: Under the same conditions with ilv_mode_i[1] = 1, chan_o is the XOR of the parity of addr_i[20:16] with addr_i[9] (ilv_mode_i[0] = 1) or with addr_i[6] (ilv_mode_i[0] = 0).
- R6: Under the same conditions with ilv_mode_i = 1, chan_o equals addr_i[12 + node_bits_i], where node_bits_i is a 2-bit count from 0 to 3.
- R7: With gang off, the high range not selected and ilv_en_i = 0, chan_o is the inverse of hi_chan_i if hi_rng_en_i = 1, and 0 otherwise.
- R8: In the high range, the subtracted offset is hole_off_i * 2^23 when sel_base_i * 2^27 < hole_base_i * 2^24, hole_vld_i = 1 and addr_i >= 2^32. Otherwise it is sel_off_i * 2^26.
- R9: Outside the high range, the subtracted offset is hole_off_i * 2^23 when hole_vld_i = 1 and addr_i >= 2^32. Otherwise it is range_base_i.
- R10: After the subtraction, bits 11:0 are kept and the bits above them are shifted right by node_bits_i.
- R11: When ilv_en_i = 1, gang is off and the high range is not selected, one more bit is squeezed out: bit 6 if ilv_mode_i[0] = 0, bit 12 if ilv_mode_i = 1, and bit 9 if ilv_mode_i = 3. The bits below it stay and the bits above it move down by one.
- R12: Results appear on chan_o and chan_addr_o with out_valid_o = 1 exactly two clock edges after req_valid_i is sampled high. out_valid_o is 0 in and after reset when there is no request. The outputs hold their values while no result is delivered, and they reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| addr_i | input | ADDR_W | Node-local system address |
| range_base_i | input | ADDR_W | Base of the node's DRAM range |
| hole_vld_i | input | 1 | Memory hole enabled |
| hole_base_i | input | HOLE_BASE_W | Hole base, units of 2^24 |
| hole_off_i | input | HOLE_OFF_W | Hole hoisting offset, units of 2^23 |
| node_bits_i | input | NODE_BITS_W | Address bits used by node interleaving (0..3) |
| gang_en_i | input | 1 | Both channels ganged |
| hi_rng_en_i | input | 1 | High range enable |
| hi_chan_i | input | 1 | Channel that owns the high range |
| ilv_en_i | input | 1 | Channel interleave enable |
| ilv_mode_i | input | 2 | Channel interleave style |
| sel_base_i | input | ADDR_W-27 | High range start, units of 2^27 |
| sel_off_i | input | ADDR_W-26 | High range offset, units of 2^26 |
| out_valid_o | output | 1 | Result valid |
| chan_o | output | 1 | Selected channel |
| chan_addr_o | output | ADDR_W | Normalized channel address |

## Verification
The high-range choice and the channel-interleave squeeze interact in a single request. Whether the interleave bit is removed depends on whether the address landed above the select base. The same is true of the hole offset, which depends both on the 4 GiB boundary and on where the select base sits relative to the hole. The sweep provokes these cases by taking every combination of the mode fields, two select bases (one under the hole base and one above it), and addresses just below, at and above the select base and at 4 GiB. Each result is judged against a channel and an address that the bench computes arithmetically with division and modulo from the rules above.

// File: rtl/dcn_pkg.sv
package dcn_pkg;
  // which single bit the channel-interleave squeeze removes
  typedef enum logic [1:0] {
    RM_NONE = 2'd0,
    RM_B6   = 2'd1,
    RM_B9   = 2'd2,
    RM_B12  = 2'd3
  } rm_e;

  function automatic logic parity5(input logic [4:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/dcn_chan_sel.sv
module dcn_chan_sel
  import dcn_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int NODE_BITS_W = 2
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [NODE_BITS_W-1:0] node_bits_i,
  input  logic                   gang_en_i,
  input  logic                   hi_rng_en_i,
  input  logic                   hi_chan_i,
  input  logic                   ilv_en_i,
  input  logic [1:0]             ilv_mode_i,
  input  logic [ADDR_W-28:0]     sel_base_i,
  output logic                   hi_sel_o,
  output logic                   chan_o,
  output rm_e                    rm_o
);
  localparam int NODE_VARIANTS = 1 << NODE_BITS_W;

  logic [ADDR_W-1:0] sel_base_addr;
  logic [NODE_VARIANTS-1:0] page_bit;

  assign sel_base_addr = {sel_base_i, 27'd0};
  assign hi_sel_o = hi_rng_en_i && !gang_en_i && (addr_i >= sel_base_addr);

  for (genvar n = 0; n < NODE_VARIANTS; n++) begin : g_page
    assign page_bit[n] = addr_i[12+n];
  end

  always_comb begin
    if (gang_en_i)                      chan_o = addr_i[3];
    else if (hi_sel_o)                  chan_o = hi_chan_i;
    else if (ilv_en_i && ilv_mode_i == 2'd0) chan_o = addr_i[6];
    else if (ilv_en_i && ilv_mode_i[1])
      chan_o = (ilv_mode_i[0] ? addr_i[9] : addr_i[6]) ^ parity5(addr_i[20:16]);
    else if (ilv_en_i)                  chan_o = page_bit[node_bits_i];
    else if (hi_rng_en_i)               chan_o = ~hi_chan_i;
    else                                chan_o = 1'b0;
  end

  always_comb begin
    rm_o = RM_NONE;
    if (ilv_en_i && !hi_sel_o && !gang_en_i) begin
      if (!ilv_mode_i[0])          rm_o = RM_B6;
      else if (ilv_mode_i == 2'd1) rm_o = RM_B12;
      else                         rm_o = RM_B9;
    end
  end
endmodule

// File: rtl/dcn_offset_sel.sv
module dcn_offset_sel #(
  parameter int ADDR_W      = 40,
  parameter int HOLE_BASE_W = 8,
  parameter int HOLE_OFF_W  = 9
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   hi_sel_i,
  input  logic [ADDR_W-1:0]      range_base_i,
  input  logic                   hole_vld_i,
  input  logic [HOLE_BASE_W-1:0] hole_base_i,
  input  logic [HOLE_OFF_W-1:0]  hole_off_i,
  input  logic [ADDR_W-28:0]     sel_base_i,
  input  logic [ADDR_W-27:0]     sel_off_i,
  output logic [ADDR_W-1:0]      off_o
);
  localparam int HOLE_PAD = ADDR_W - HOLE_OFF_W - 23;
  localparam int HB_PAD   = ADDR_W - HOLE_BASE_W - 24;

  logic [ADDR_W-1:0] hole_off_addr, hole_base_addr, sel_base_addr, sel_off_addr;
  logic              above_4g, hole_applies;

  assign hole_off_addr  = {{HOLE_PAD{1'b0}}, hole_off_i, 23'd0};
  assign hole_base_addr = {{HB_PAD{1'b0}}, hole_base_i, 24'd0};
  assign sel_base_addr  = {sel_base_i, 27'd0};
  assign sel_off_addr   = {sel_off_i, 26'd0};
  assign above_4g       = |addr_i[ADDR_W-1:32];
  assign hole_applies   = hole_vld_i && above_4g;

  always_comb begin
    if (hi_sel_i)
      off_o = (hole_applies && (sel_base_addr < hole_base_addr)) ? hole_off_addr : sel_off_addr;
    else
      off_o = hole_applies ? hole_off_addr : range_base_i;
  end
endmodule

// File: rtl/dcn_squeeze.sv
module dcn_squeeze
  import dcn_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int NODE_BITS_W = 2
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [NODE_BITS_W-1:0] node_bits_i,
  input  rm_e                    rm_i,
  output logic [ADDR_W-1:0]      addr_o
);
  localparam int NODE_VARIANTS = 1 << NODE_BITS_W;

  logic [ADDR_W-1:0] node_v [NODE_VARIANTS];
  logic [ADDR_W-1:0] node_addr;

  for (genvar n = 0; n < NODE_VARIANTS; n++) begin : g_node
    assign node_v[n] = ((addr_i >> (12 + n)) << 12) | {{(ADDR_W-12){1'b0}}, addr_i[11:0]};
  end
  assign node_addr = node_v[node_bits_i];

  function automatic logic [ADDR_W-1:0] drop_bit(input logic [ADDR_W-1:0] v, input int k);
    logic [ADDR_W-1:0] low_mask;
    low_mask = (ADDR_W'(1) << k) - ADDR_W'(1);
    return ((v >> (k + 1)) << k) | (v & low_mask);
  endfunction

  always_comb begin
    unique case (rm_i)
      RM_B6:   addr_o = drop_bit(node_addr, 6);
      RM_B9:   addr_o = drop_bit(node_addr, 9);
      RM_B12:  addr_o = drop_bit(node_addr, 12);
      default: addr_o = node_addr;
    endcase
  end

  // squeezing never grows the address and never touches bits 5:0
  always_comb begin
    p_no_grow_r10: assert (addr_o <= addr_i);
    p_low_keep_r11: assert (addr_o[5:0] == addr_i[5:0]);
  end
endmodule

// File: rtl/dram_chan_norm.sv
module dram_chan_norm
  import dcn_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int HOLE_BASE_W = 8,
  parameter int HOLE_OFF_W  = 9,
  parameter int NODE_BITS_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [ADDR_W-1:0]      range_base_i,
  input  logic                   hole_vld_i,
  input  logic [HOLE_BASE_W-1:0] hole_base_i,
  input  logic [HOLE_OFF_W-1:0]  hole_off_i,
  input  logic [NODE_BITS_W-1:0] node_bits_i,
  input  logic                   gang_en_i,
  input  logic                   hi_rng_en_i,
  input  logic                   hi_chan_i,
  input  logic                   ilv_en_i,
  input  logic [1:0]             ilv_mode_i,
  input  logic [ADDR_W-28:0]     sel_base_i,
  input  logic [ADDR_W-27:0]     sel_off_i,
  output logic                   out_valid_o,
  output logic                   chan_o,
  output logic [ADDR_W-1:0]      chan_addr_o
);
  logic              hi_sel, chan_c;
  rm_e               rm_c;
  logic [ADDR_W-1:0] off_c;

  logic                   s1_valid, s1_chan, s1_hi, s1_gang;
  logic [ADDR_W-1:0]      s1_addr, s1_off;
  logic [NODE_BITS_W-1:0] s1_node;
  rm_e                    s1_rm;
  logic [ADDR_W-1:0]      sub_addr, sq_addr;

  dcn_chan_sel #(.ADDR_W(ADDR_W), .NODE_BITS_W(NODE_BITS_W)) u_chan (
    .addr_i(addr_i), .node_bits_i(node_bits_i), .gang_en_i(gang_en_i),
    .hi_rng_en_i(hi_rng_en_i), .hi_chan_i(hi_chan_i), .ilv_en_i(ilv_en_i),
    .ilv_mode_i(ilv_mode_i), .sel_base_i(sel_base_i),
    .hi_sel_o(hi_sel), .chan_o(chan_c), .rm_o(rm_c)
  );

  dcn_offset_sel #(.ADDR_W(ADDR_W), .HOLE_BASE_W(HOLE_BASE_W), .HOLE_OFF_W(HOLE_OFF_W)) u_off (
    .addr_i(addr_i), .hi_sel_i(hi_sel), .range_base_i(range_base_i),
    .hole_vld_i(hole_vld_i), .hole_base_i(hole_base_i), .hole_off_i(hole_off_i),
    .sel_base_i(sel_base_i), .sel_off_i(sel_off_i), .off_o(off_c)
  );

  // stage 1: decisions
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_chan  <= 1'b0;
      s1_hi    <= 1'b0;
      s1_gang  <= 1'b0;
      s1_addr  <= '0;
      s1_off   <= '0;
      s1_node  <= '0;
      s1_rm    <= RM_NONE;
    end else begin
      s1_valid <= req_valid_i;
      if (req_valid_i) begin
        s1_chan <= chan_c;
        s1_hi   <= hi_sel;
        s1_gang <= gang_en_i;
        s1_addr <= addr_i;
        s1_off  <= off_c;
        s1_node <= node_bits_i;
        s1_rm   <= rm_c;
      end
    end
  end

  assign sub_addr = s1_addr - s1_off;

  dcn_squeeze #(.ADDR_W(ADDR_W), .NODE_BITS_W(NODE_BITS_W)) u_sq (
    .addr_i(sub_addr), .node_bits_i(s1_node), .rm_i(s1_rm), .addr_o(sq_addr)
  );

  // stage 2: normalized result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      chan_o      <= 1'b0;
      chan_addr_o <= '0;
    end else begin
      out_valid_o <= s1_valid;
      if (s1_valid) begin
        chan_o      <= s1_chan;
        chan_addr_o <= sq_addr;
      end
    end
  end

  p_valid_pipe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |=> out_valid_o);
  p_no_spurious_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid |=> !out_valid_o);
  p_out_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid |=> ($stable(chan_addr_o) && $stable(chan_o)));
  p_hi_not_gang_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |-> !(s1_hi && s1_gang));
endmodule

// File: tb/dram_chan_norm_test.sv
module dram_chan_norm_test;
  localparam int  CLK_PERIOD = 10;
  localparam int  AW = 40;
  localparam longint unsigned AMASK = (64'd1 << AW) - 1;

  logic            clk_i = 1'b0, rst_ni = 1'b0, req_valid_i = 1'b0;
  logic [AW-1:0]   addr_i = '0, range_base_i = '0;
  logic            hole_vld_i = 1'b0;
  logic [7:0]      hole_base_i = '0;
  logic [8:0]      hole_off_i = '0;
  logic [1:0]      node_bits_i = '0;
  logic            gang_en_i = 1'b0, hi_rng_en_i = 1'b0, hi_chan_i = 1'b0, ilv_en_i = 1'b0;
  logic [1:0]      ilv_mode_i = '0;
  logic [AW-28:0]  sel_base_i = '0;
  logic [AW-27:0]  sel_off_i = '0;
  logic            out_valid_o, chan_o;
  logic [AW-1:0]   chan_addr_o;

  int n_chk = 0, n_bad = 0;

  dram_chan_norm uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint unsigned pw2(input int k);
    return 64'd1 << k;
  endfunction

  function automatic longint unsigned squeeze_at(input longint unsigned v, input int k);
    return (v / pw2(k + 1)) * pw2(k) + (v % pw2(k));
  endfunction

  task automatic one_req(input longint unsigned a);
    longint unsigned sb, hb, off, x;
    bit hi, ch, par;
    string ctag, atag;
    int nb;
    nb  = int'(node_bits_i);
    sb  = longint'(sel_base_i) * pw2(27);
    hb  = longint'(hole_base_i) * pw2(24);
    hi  = hi_rng_en_i && !gang_en_i && (a >= sb);
    par = 1'b0;
    for (int i = 16; i <= 20; i++) par ^= a[i];
    if (gang_en_i)                        begin ch = a[3]; ctag = "R2"; end
    else if (hi)                          begin ch = hi_chan_i; ctag = "R1 R3"; end
    else if (ilv_en_i && ilv_mode_i == 0) begin ch = a[6]; ctag = "R4"; end
    else if (ilv_en_i && ilv_mode_i >= 2) begin ch = (ilv_mode_i == 3 ? a[9] : a[6]) ^ par; ctag = "R5"; end
    else if (ilv_en_i)                    begin ch = a[12 + nb]; ctag = "R6"; end
    else if (hi_rng_en_i)                 begin ch = !hi_chan_i; ctag = "R1 R7"; end
    else                                  begin ch = 1'b0; ctag = "R7"; end
    if (hi) begin
      atag = "R8 R10 R11";
      off = (hole_vld_i && a >= pw2(32) && sb < hb) ? longint'(hole_off_i) * pw2(23)
                                                     : longint'(sel_off_i) * pw2(26);
    end else begin
      atag = "R9 R10 R11";
      off = (hole_vld_i && a >= pw2(32)) ? longint'(hole_off_i) * pw2(23) : longint'(range_base_i);
    end
    x = (a - off) & AMASK;
    x = (x / pw2(12 + nb)) * 4096 + (x % 4096);
    if (ilv_en_i && !hi && !gang_en_i) begin
      if (ilv_mode_i == 0 || ilv_mode_i == 2) x = squeeze_at(x, 6);
      else if (ilv_mode_i == 1)               x = squeeze_at(x, 12);
      else                                    x = squeeze_at(x, 9);
    end
    @(negedge clk_i);
    addr_i = a[AW-1:0];
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R12 valid after one stage", longint'(out_valid_o), 0);
    @(negedge clk_i);
    check("R12 valid after two stages", longint'(out_valid_o), 1);
    check(ctag, longint'(chan_o), longint'(ch));
    check(atag, longint'(chan_addr_o), x);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint unsigned base, addrs [7];
    hole_base_i  = 8'hC0;   // 3 GiB
    hole_off_i   = 9'h080;  // 1 GiB
    sel_off_i    = 14'h020; // 2 GiB
    range_base_i = 40'h0;
    repeat (3) @(negedge clk_i);
    check("R12 reset valid", longint'(out_valid_o), 0);
    check("R12 reset addr", longint'(chan_addr_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R12 idle valid", longint'(out_valid_o), 0);
    for (int sbs = 0; sbs < 2; sbs++) begin
      sel_base_i = (sbs == 0) ? 13'h010 : 13'h030; // 2 GiB under hole, 6 GiB above
      for (int cfg = 0; cfg < 512; cfg++) begin
        {hole_vld_i, node_bits_i, ilv_mode_i, ilv_en_i, hi_chan_i, hi_rng_en_i, gang_en_i} = 9'(cfg);
        base = longint'(sel_base_i) * pw2(27);
        addrs[0] = longint'($urandom) & 64'h7FFF_FFFF;
        addrs[1] = pw2(32);
        addrs[2] = base - 1;
        addrs[3] = base;
        addrs[4] = ({longint'($urandom), longint'($urandom)} ) & AMASK;
        addrs[5] = pw2(32) + (longint'($urandom) & 64'h1_FFFF_FFFF);
        addrs[6] = 64'hC000_0000 + (longint'($urandom) & 64'h3FFF_FFFF);
        for (int k = 0; k < 7; k++) begin
          if (k == 4 || k == 6 || (cfg % 4 == 0)) one_req(addrs[k]);
        end
      end
    end
    // outputs hold when idle
    @(negedge clk_i);
    base = longint'(chan_addr_o);
    repeat (3) @(negedge clk_i);
    check("R12 hold when idle", longint'(chan_addr_o), base);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule